// File: doc/BRIEF.md
# Shared-RAM Multi-Queue FIFO

This block keeps up to four independent FIFO queues in a single on-chip RAM, carved into equal-sized blocks. Each queue owns a contiguous run of blocks, chosen at configuration time by a start block and a block count. Its depth is that count times the block size, and its pointers wrap inside that run only. One clock serves both ports. The write port steers each word to the queue named by its select input. The read port presents the head of the queue named by its select in first-word-fall-through style.

Each queue keeps its own almost-full and almost-empty thresholds. The write port reports full and almost-full for the queue it currently selects. The read port reports output-valid and almost-empty for its selected queue. Configuration is written while a config-enable input is held high, and holding it empties every queue.

Top module: `mq_fifo`

## Requirements
- R1: While `cfg_en` is high, a pulse on `cfg_we` stores start block, block count, almost-full level and almost-empty level for queue `cfg_q`. The stored values remain after `cfg_en` falls. While `cfg_en` is high, every queue is emptied, writes and reads are ignored, and `rd_valid` is low from the next cycle on. Reset gives every queue zero blocks.
- R2: A queue holds exactly its block count times `BLK_WORDS` words. `full` rises when that many words are stored.
- R3: A write to a full queue is dropped. The words already stored are read back unchanged and in order.
- R4: `full` and `almost_full` describe the queue selected by `wr_q`. `almost_full` is high when that queue's stored word count is at least its almost-full level.
- R5: Once a queue holds data and is selected by `rd_q`, its oldest word appears on `rd_data` with `rd_valid` high, with no read enable needed. The word appears two clock edges after it was written into an empty queue. A cycle with `rd_en` and `rd_valid` both high removes that word, and the next word appears after that edge.
- R6: `rd_valid` is low whenever the selected read queue is empty. `rd_en` then has no effect.
- R7: When `rd_q` moves to an empty queue, `rd_data` keeps the last word shown, with `rd_valid` low.
- R8: `almost_empty` is high when the stored word count of the queue selected by `rd_q` is at or below its almost-empty level. The count includes the word on display.
- R9: A write and a read of the same queue in one cycle leave its word count unchanged. Traffic on one queue does not change another queue's contents.
- R10: The pointers of a queue wrap inside its own block range, and word order is kept across the wrap.
- R11: A queue with zero blocks always reports `full` and never raises `rd_valid`.
- R12: A word that is shown but not read stays at the head of its queue when the read select moves away. It is shown again when that queue is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Configuration mode; clears all queues |
| cfg_we | input | 1 | Store configuration for `cfg_q` |
| cfg_q | input | QW | Queue being configured |
| cfg_start | input | SBW | First block of the queue |
| cfg_nblk | input | NBW | Number of blocks (0 allowed) |
| cfg_af | input | CW | Almost-full word level |
| cfg_ae | input | CW | Almost-empty word level |
| wr_en | input | 1 | Write enable |
| wr_q | input | QW | Write queue select |
| wr_data | input | DW | Write data |
| full | output | 1 | Selected write queue is full |
| almost_full | output | 1 | Selected write queue at or above its level |
| rd_en | input | 1 | Read (pop) enable |
| rd_q | input | QW | Read queue select |
| rd_data | output | DW | Output register |
| rd_valid | output | 1 | `rd_data` is the head of the selected queue |
| almost_empty | output | 1 | Selected read queue at or below its level |

## Verification
The main function is driven with four kinds of pattern.
- A vector table interleaves writes, pops and select changes across three queues. It separates real fall-through from a held word: `rd_data` is checked even while `rd_valid` is low.
- A same-cycle write and pop on one queue shows whether the word count stays put, because the next head must appear one cycle late.
- A fill past capacity after a partial drain makes the pointers wrap. The ordered read-back then tells a dropped overflow word apart from one that overwrote data.
- A zero-block queue and a reconfiguration pass check the full and empty extremes and the clearing done by config mode.

// File: rtl/mq_fifo.sv
module mq_fifo #(
  parameter int DW        = 16,
  parameter int NQ        = 4,
  parameter int NBLK      = 8,
  parameter int BLK_WORDS = 16,
  localparam int QW    = $clog2(NQ),
  localparam int DEPTH = NBLK * BLK_WORDS,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int SBW   = $clog2(NBLK),
  localparam int NBW   = $clog2(NBLK + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_en,
  input  logic           cfg_we,
  input  logic [QW-1:0]  cfg_q,
  input  logic [SBW-1:0] cfg_start,
  input  logic [NBW-1:0] cfg_nblk,
  input  logic [CW-1:0]  cfg_af,
  input  logic [CW-1:0]  cfg_ae,
  input  logic           wr_en,
  input  logic [QW-1:0]  wr_q,
  input  logic [DW-1:0]  wr_data,
  output logic           full,
  output logic           almost_full,
  input  logic           rd_en,
  input  logic [QW-1:0]  rd_q,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid,
  output logic           almost_empty
);

  logic [DW-1:0]  mem     [DEPTH];
  logic [SBW-1:0] start_r [NQ];
  logic [NBW-1:0] nblk_r  [NQ];
  logic [CW-1:0]  af_r [NQ], ae_r [NQ], cnt [NQ], cap [NQ];
  logic [AW-1:0]  woff [NQ], roff [NQ];
  logic           v_r;
  logic [QW-1:0]  vq;
  logic [DW-1:0]  dout;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] off, input logic [CW-1:0] c);
    return (CW'(off) + CW'(1) == c) ? '0 : off + AW'(1);
  endfunction

  always_comb
    for (int q = 0; q < NQ; q++) cap[q] = CW'(nblk_r[q]) * CW'(BLK_WORDS);

  logic          wr_ok, rd_ok, have;
  logic [AW-1:0] waddr, raddr;

  assign full         = cnt[wr_q] == cap[wr_q];
  assign almost_full  = cnt[wr_q] >= af_r[wr_q];
  assign almost_empty = cnt[rd_q] <= ae_r[rd_q];
  assign rd_valid     = v_r && (vq == rd_q);
  assign rd_data      = dout;
  assign wr_ok        = wr_en && !cfg_en && !full;
  assign rd_ok        = rd_en && rd_valid && !cfg_en;
  assign have         = rd_ok ? (cnt[rd_q] > CW'(1)) : (cnt[rd_q] != '0);
  assign waddr        = AW'(start_r[wr_q]) * AW'(BLK_WORDS) + woff[wr_q];
  assign raddr        = AW'(start_r[rd_q]) * AW'(BLK_WORDS)
                      + (rd_ok ? step(roff[rd_q], cap[rd_q]) : roff[rd_q]);

  always_ff @(posedge clk)
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        start_r[q] <= '0; nblk_r[q] <= '0; af_r[q] <= '0; ae_r[q] <= '0;
      end
    end else if (cfg_en && cfg_we) begin
      start_r[cfg_q] <= cfg_start;
      nblk_r[cfg_q]  <= cfg_nblk;
      af_r[cfg_q]    <= cfg_af;
      ae_r[cfg_q]    <= cfg_ae;
    end

  always_ff @(posedge clk)
    if (!rst_n || cfg_en) begin
      for (int q = 0; q < NQ; q++) begin
        cnt[q] <= '0; woff[q] <= '0; roff[q] <= '0;
      end
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (wr_ok && wr_q == QW'(q)) woff[q] <= step(woff[q], cap[q]);
        if (rd_ok && rd_q == QW'(q)) roff[q] <= step(roff[q], cap[q]);
        if ((wr_ok && wr_q == QW'(q)) && !(rd_ok && rd_q == QW'(q)))
          cnt[q] <= cnt[q] + CW'(1);
        else if (!(wr_ok && wr_q == QW'(q)) && (rd_ok && rd_q == QW'(q)))
          cnt[q] <= cnt[q] - CW'(1);
      end
    end

  always_ff @(posedge clk)
    if (wr_ok) mem[waddr] <= wr_data;

  always_ff @(posedge clk)
    if (!rst_n) begin
      v_r <= 1'b0; vq <= '0; dout <= '0;
    end else if (cfg_en) begin
      v_r <= 1'b0;
    end else begin
      v_r <= have;
      vq  <= rd_q;
      if (have) dout <= mem[raddr];
    end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[wr_q] <= cap[wr_q]);
  a_r11_zero_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cap[wr_q] == '0) |-> full);
  a_r11_zero_never_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (cap[rd_q] == '0) |-> !rd_valid);
  a_r6_valid_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (cnt[rd_q] != '0));
  a_r7_hold_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && cnt[rd_q] == '0) |=> $stable(rd_data));
  a_r1_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> !rd_valid);

endmodule

// File: tb/mq_fifo_tb.sv
module mq_fifo_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_en = 0, cfg_we = 0;
  logic [1:0] cfg_q = 0;
  logic [2:0] cfg_start = 0;
  logic [3:0] cfg_nblk = 0;
  logic [7:0] cfg_af = 0, cfg_ae = 0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] wr_q = 0, rd_q = 0;
  logic [15:0] wr_data = 0;
  logic full, almost_full, rd_valid, almost_empty;
  logic [15:0] rd_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mq_fifo u_dut (.clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_q(cfg_q),
    .cfg_start(cfg_start), .cfg_nblk(cfg_nblk), .cfg_af(cfg_af), .cfg_ae(cfg_ae),
    .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data), .full(full), .almost_full(almost_full),
    .rd_en(rd_en), .rd_q(rd_q), .rd_data(rd_data), .rd_valid(rd_valid),
    .almost_empty(almost_empty));

  typedef struct packed {
    logic we; logic [1:0] wq; logic [15:0] wd; logic re; logic [1:0] rq;
    logic ev; logic [15:0] ed; logic ef; logic eaf; logic eae;
  } vec_t;

  // rows 6-7: R7 hold on empty; row 8: R9 same-queue write+read;
  // rows 11-12: R11 zero-block queue; rows 13-14: R12 head kept after switch
  localparam vec_t TBL [15] = '{
    '{1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1},
    '{1'b1, 2'd0, 16'hA001, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1},
    '{1'b1, 2'd0, 16'hA002, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1},
    '{1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b1, 16'hA001, 1'b0, 1'b0, 1'b0},
    '{1'b0, 2'd0, 16'h0000, 1'b1, 2'd0, 1'b1, 16'hA001, 1'b0, 1'b0, 1'b0},
    '{1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b1, 16'hA002, 1'b0, 1'b0, 1'b1},
    '{1'b1, 2'd1, 16'hB001, 1'b0, 2'd1, 1'b0, 16'hA002, 1'b0, 1'b0, 1'b1},
    '{1'b0, 2'd1, 16'h0000, 1'b0, 2'd1, 1'b0, 16'hA002, 1'b0, 1'b0, 1'b1},
    '{1'b1, 2'd1, 16'hB002, 1'b1, 2'd1, 1'b1, 16'hB001, 1'b0, 1'b0, 1'b1},
    '{1'b0, 2'd1, 16'h0000, 1'b0, 2'd1, 1'b0, 16'hB001, 1'b0, 1'b0, 1'b1},
    '{1'b0, 2'd1, 16'h0000, 1'b0, 2'd1, 1'b1, 16'hB002, 1'b0, 1'b0, 1'b1},
    '{1'b1, 2'd2, 16'hDEAD, 1'b0, 2'd2, 1'b0, 16'hB002, 1'b1, 1'b1, 1'b1},
    '{1'b0, 2'd2, 16'h0000, 1'b0, 2'd2, 1'b0, 16'hB002, 1'b1, 1'b1, 1'b1},
    '{1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b0, 16'hB002, 1'b0, 1'b0, 1'b1},
    '{1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b1, 16'hA002, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int q, input int st, input int nb, input int af, input int ae);
    @(negedge clk);
    cfg_en = 1; cfg_we = 1; cfg_q = 2'(q); cfg_start = 3'(st); cfg_nblk = 4'(nb);
    cfg_af = 8'(af); cfg_ae = 8'(ae);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic read_one(input int q, input int exp, input string tag);
    int n = 0;
    @(negedge clk);
    rd_q = 2'(q); rd_en = 0; #1;
    while (!rd_valid && n < 6) begin @(negedge clk); #1; n++; end
    chk(rd_valid && rd_data == 16'(exp), tag, int'(rd_data), exp);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(full == 1'b1, "R1 reset leaves zero blocks (full)", int'(full), 1);
    chk(rd_valid == 1'b0, "R1 reset rd_valid", int'(rd_valid), 0);
    chk(rd_data == 16'h0, "R1 reset rd_data", int'(rd_data), 0);
    @(negedge clk); rst_n = 1;

    cfg(0, 0, 1, 14, 1);
    cfg(1, 1, 2, 30, 2);
    cfg(2, 3, 0, 0, 0);
    cfg(3, 3, 1, 3, 0);
    @(negedge clk); cfg_en = 0;

    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      wr_en = TBL[i].we; wr_q = TBL[i].wq; wr_data = TBL[i].wd;
      rd_en = TBL[i].re; rd_q = TBL[i].rq;
      #1;
      chk(rd_valid == TBL[i].ev, $sformatf("R5 rd_valid row %0d", i), int'(rd_valid), int'(TBL[i].ev));
      chk(rd_data == TBL[i].ed, $sformatf("R7 rd_data row %0d", i), int'(rd_data), int'(TBL[i].ed));
      chk(full == TBL[i].ef, $sformatf("R4 full row %0d", i), int'(full), int'(TBL[i].ef));
      chk(almost_full == TBL[i].eaf, $sformatf("R4 almost_full row %0d", i), int'(almost_full), int'(TBL[i].eaf));
      chk(almost_empty == TBL[i].eae, $sformatf("R8 almost_empty row %0d", i), int'(almost_empty), int'(TBL[i].eae));
    end
    @(negedge clk); wr_en = 0; rd_en = 0;

    // R10: partial fill and drain of queue 3 moves its pointers to offset 10
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); wr_en = 1; wr_q = 3; wr_data = 16'(300 + i);
    end
    @(negedge clk); wr_en = 0;
    for (int i = 0; i < 10; i++) read_one(3, 300 + i, "R10 first pass order");

    // R2/R4: 16-word capacity, almost_full from 3 words
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); wr_q = 3; wr_en = 0; #1;
      chk(full == 1'b0, "R2 not full below capacity", int'(full), 0);
      chk(almost_full == (i >= 3), "R4 almost_full level", int'(almost_full), int'(i >= 3));
      wr_en = 1; wr_data = 16'(400 + i);
    end
    @(negedge clk); wr_en = 1; wr_data = 16'hFFFF; #1;
    chk(full == 1'b1, "R2 full at capacity", int'(full), 1);
    @(negedge clk); wr_en = 0;
    // R3/R10: overflow word dropped, order kept across the wrap
    for (int i = 0; i < 16; i++) read_one(3, 400 + i, "R3 R10 wrapped read order");
    @(negedge clk); rd_q = 3; rd_en = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(rd_valid == 1'b0, "R6 empty queue not valid", int'(rd_valid), 0);
    chk(almost_empty == 1'b1, "R8 almost_empty on empty", int'(almost_empty), 1);
    rd_en = 0;
    @(negedge clk); wr_en = 1; wr_q = 3; wr_data = 16'h0500;
    @(negedge clk); wr_en = 0;
    read_one(3, 16'h0500, "R6 rd_en on empty had no effect");

    // R9: queue 1 untouched by all queue 3 traffic
    read_one(1, 16'hB002, "R9 other queue intact");
    read_one(0, 16'hA002, "R12 queue 0 head kept");

    // R1: config mode clears queues, blocks writes, keeps settings
    @(negedge clk); wr_en = 1; wr_q = 1; wr_data = 16'h1111;
    @(negedge clk); wr_en = 0; rd_q = 1;
    repeat (2) @(negedge clk);
    #1;
    chk(rd_valid == 1'b1, "R5 queue 1 valid before config", int'(rd_valid), 1);
    cfg_en = 1; wr_en = 1; wr_q = 1; wr_data = 16'h2222;
    @(negedge clk); #1;
    chk(rd_valid == 1'b0, "R1 config mode drops rd_valid", int'(rd_valid), 0);
    cfg(0, 0, 1, 1, 1);
    @(negedge clk); cfg_en = 0; wr_en = 0; rd_q = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(rd_valid == 1'b0, "R1 queue 1 emptied, write ignored", int'(rd_valid), 0);
    chk(almost_empty == 1'b1, "R1 queue 1 count zero", int'(almost_empty), 1);
    wr_q = 0; #1;
    chk(almost_full == 1'b0, "R1 new level, empty queue 0", int'(almost_full), 0);
    wr_en = 1; wr_data = 16'h0777;
    @(negedge clk); wr_en = 0; #1;
    chk(almost_full == 1'b1, "R1 new almost_full level applied", int'(almost_full), 1);
    read_one(0, 16'h0777, "R5 fall-through after reconfig");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule